// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked host and an external asynchronous static RAM with a 17-bit address, an 8-bit data path and two chip selects: one active low, one active high. The host hands over one word per request through a valid/ready handshake. Each request carries an address, write data and a write flag. Reads come back on a data port with a single-cycle valid pulse. The controller turns every request into a strobe sequence in which each phase lasts a whole number of clock cycles. The cycle counts are parameters, chosen by rounding the memory's nanosecond minimums up to whole clock periods.

Every access goes through the same phases. First the address is set up alone. Then comes a strobe phase: output enable for a read, write enable for a write. Last comes a short gap in which all strobes are released and the bus is let go while the address still holds. During writes, output enable stays high. The write data drivers switch on only after a turnaround delay from the fall of write enable, because the memory may still be driving the pins when write enable drops.

If no request arrives for a set number of cycles, both chip selects go to their inactive levels and the memory drops into standby. Out of reset the memory is also in standby. A request that finds the memory in standby first reselects it and waits a recovery period before any strobe is asserted.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: During and after reset, until the first request, req_ready is 1, mem_cs_n is 1, mem_cs is 0, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, rd_valid is 0 and rd_data is 0.
- R2: mem_oe_n or mem_we_n is low only while the memory is selected (mem_cs_n = 0 and mem_cs = 1). Outside standby both selects stay at their active levels.
- R3: A read holds mem_oe_n low, with mem_we_n high and mem_dq_oe low, for exactly RD_CYC consecutive cycles. The read data is taken from mem_dq_in in the last of those cycles and appears on rd_data with rd_valid high for exactly one cycle, in the following cycle.
- R4: A write holds mem_we_n low for exactly WE_CYC consecutive cycles, with mem_oe_n high the whole time. The address is stable for at least SETUP_CYC cycles before mem_we_n falls and stays stable until after it rises.
- R5: mem_dq_oe is 1 only while mem_we_n is low, and never within the first TURN_CYC cycles of the low pulse. Write data is therefore driven for WE_CYC - TURN_CYC cycles ending at the rise of mem_we_n.
- R6: mem_addr changes only in a cycle that follows one with mem_we_n high, mem_oe_n high and mem_dq_oe low. Every access ends with GAP_CYC such cycles.
- R7: req_ready is 1 only while no access is in progress. A request is accepted on a rising edge where req_valid and req_ready are both 1. req_ready then stays 0 for SETUP_CYC + WE_CYC + GAP_CYC cycles after a write and SETUP_CYC + RD_CYC + GAP_CYC cycles after a read.
- R8: After IDLE_CYC consecutive cycles with the memory selected, no access in progress and no request, mem_cs_n goes to 1 and mem_cs to 0. The memory stays selected throughout the first IDLE_CYC cycles.
- R9: A request accepted while in standby reselects the memory and holds it selected, with no strobe, for RECOV_CYC cycles before the setup phase. req_ready stays low for RECOV_CYC cycles longer than in R7.
- R10: A read returns the byte last written to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Data for a write request |
| req_write | input | 1 | 1 = write, 0 = read |
| rd_valid | output | 1 | One-cycle pulse, rd_data holds read data |
| rd_data | output | DATA_W | Returned read data |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable of the data bus drivers |
| mem_dq_in | input | DATA_W | Data read from the memory pins |

## Verification
The bench builds the controller with SETUP_CYC 1, WE_CYC 4, TURN_CYC 2, RD_CYC 3, GAP_CYC 1, RECOV_CYC 5 and IDLE_CYC 16. These short windows bring the idle timeout and the standby recovery within reach after a few dozen cycles. Because the turnaround is shorter than the write pulse, the cycle model in the bench sees both a bus-released stretch and a driven stretch inside every write. The model also serves reads only once output enable has been low for the read count, so a read captured one cycle early would return a garbage byte.

// File: rtl/sram_ctrl_pkg.sv
// Shared types for the asynchronous SRAM strobe controller.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package sram_ctrl_pkg;

    // Access phases; each lasts a parameterised number of clock cycles.
    typedef enum logic [2:0] {
        PH_STANDBY = 3'd0,
        PH_WAKE    = 3'd1,
        PH_IDLE    = 3'd2,
        PH_SETUP   = 3'd3,
        PH_WRITE   = 3'd4,
        PH_READ    = 3'd5,
        PH_GAP     = 3'd6
    } phase_e;

    // Larger of two cycle counts, used to size the phase counter.
    function automatic int max_cycles(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Phase cycle counter: restarts at zero when a new phase begins and
// saturates at all ones. Exposes both the registered count and the
// count the next cycle will hold, so pin registers can align to it.
module sram_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_d
);

    // Next count: zero on phase change, else increment with saturation.
    always_comb begin
        if (restart)
            cnt_d = '0;
        else if (&cnt_q)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

endmodule

// File: rtl/sram_seq_fsm.sv
// Access sequencer: walks standby, wake, idle, setup, strobe and gap
// phases, each for its parameterised number of cycles. Assumes every
// cycle count is at least 1 and fits in CW bits.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CW        = 8,
    parameter int SETUP_CYC = 2,
    parameter int WE_CYC    = 12,
    parameter int RD_CYC    = 12,
    parameter int GAP_CYC   = 1,
    parameter int RECOV_CYC = 14,
    parameter int IDLE_CYC  = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          op_write,
    input  logic [CW-1:0] cnt_q,
    output phase_e        ph_q,
    output phase_e        ph_d,
    output logic          accept,
    output logic          capture,
    output logic          restart
);

    logic [CW-1:0] len_m1;
    logic          last;

    // Final count value of the current phase.
    always_comb begin
        case (ph_q)
            PH_WAKE:  len_m1 = CW'(RECOV_CYC - 1);
            PH_IDLE:  len_m1 = CW'(IDLE_CYC - 1);
            PH_SETUP: len_m1 = CW'(SETUP_CYC - 1);
            PH_WRITE: len_m1 = CW'(WE_CYC - 1);
            PH_READ:  len_m1 = CW'(RD_CYC - 1);
            PH_GAP:   len_m1 = CW'(GAP_CYC - 1);
            default:  len_m1 = '0;
        endcase
    end

    assign last    = (cnt_q == len_m1);
    assign accept  = req_valid && ((ph_q == PH_STANDBY) || (ph_q == PH_IDLE));
    assign capture = (ph_q == PH_READ) && last;
    assign restart = (ph_d != ph_q);

    // Next phase selection.
    always_comb begin
        ph_d = ph_q;
        case (ph_q)
            PH_STANDBY: if (accept) ph_d = PH_WAKE;
            PH_WAKE:    if (last)   ph_d = PH_SETUP;
            PH_IDLE: begin
                if (accept)    ph_d = PH_SETUP;
                else if (last) ph_d = PH_STANDBY;
            end
            PH_SETUP:   if (last)   ph_d = op_write ? PH_WRITE : PH_READ;
            PH_WRITE:   if (last)   ph_d = PH_GAP;
            PH_READ:    if (last)   ph_d = PH_GAP;
            PH_GAP:     if (last)   ph_d = PH_IDLE;
            default:    ph_d = PH_STANDBY;
        endcase
    end

    // Phase register; reset leaves the memory deselected.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph_q <= PH_STANDBY;
        else
            ph_q <= ph_d;
    end

endmodule

// File: rtl/sram_pin_driver.sv
// Memory control pin registers. Decodes the next phase and next count
// so every strobe leaves a flop aligned with the phase register and
// carries no decode glitches. Write drivers switch on TURN_CYC cycles
// into the write pulse; assumes 1 <= TURN_CYC < WE_CYC.
module sram_pin_driver
    import sram_ctrl_pkg::*;
#(
    parameter int CW       = 8,
    parameter int TURN_CYC = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        ph_d,
    input  logic [CW-1:0] cnt_d,
    output logic          mem_cs_n,
    output logic          mem_cs,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic          mem_dq_oe
);

    logic sel_d, oe_d, we_d, drv_d;

    // Pin levels implied by the coming phase.
    always_comb begin
        sel_d = (ph_d != PH_STANDBY);
        oe_d  = (ph_d == PH_READ);
        we_d  = (ph_d == PH_WRITE);
        drv_d = we_d && (cnt_d >= CW'(TURN_CYC));
    end

    // Registered pins; reset deselects and releases everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cs_n  <= 1'b1;
            mem_cs    <= 1'b0;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_cs_n  <= !sel_d;
            mem_cs    <= sel_d;
            mem_oe_n  <= !oe_d;
            mem_we_n  <= !we_d;
            mem_dq_oe <= drv_d;
        end
    end

endmodule

// File: rtl/sram_strobe_ctrl.sv
// Top of the asynchronous SRAM strobe controller. Latches one host
// request at a time, sequences the memory strobes through the phase
// FSM and returns read data with a one-cycle valid pulse. Assumes the
// host holds req_* stable while req_valid is high and not yet accepted.
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int SETUP_CYC = 2,
    parameter int WE_CYC    = 12,
    parameter int TURN_CYC  = 5,
    parameter int RD_CYC    = 12,
    parameter int GAP_CYC   = 1,
    parameter int RECOV_CYC = 14,
    parameter int IDLE_CYC  = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int MAXL = max_cycles(max_cycles(max_cycles(SETUP_CYC, WE_CYC),
                                                max_cycles(RD_CYC, GAP_CYC)),
                                     max_cycles(RECOV_CYC, IDLE_CYC));
    localparam int CW   = $clog2(MAXL + 1);

    phase_e            ph_q, ph_d;
    logic              accept, capture, restart;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_wdata;
    logic              op_write;

    assign req_ready  = (ph_q == PH_STANDBY) || (ph_q == PH_IDLE);
    assign mem_addr   = op_addr;
    assign mem_dq_out = op_wdata;

    // Request latch: address, data and direction held for the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_addr  <= '0;
            op_wdata <= '0;
            op_write <= 1'b0;
        end else if (accept) begin
            op_addr  <= req_addr;
            op_wdata <= req_wdata;
            op_write <= req_write;
        end
    end

    // Read return: sample the pins on the last output-enable cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture)
                rd_data <= mem_dq_in;
        end
    end

    sram_phase_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .cnt_q   (cnt_q),
        .cnt_d   (cnt_d)
    );

    sram_seq_fsm #(
        .CW        (CW),
        .SETUP_CYC (SETUP_CYC),
        .WE_CYC    (WE_CYC),
        .RD_CYC    (RD_CYC),
        .GAP_CYC   (GAP_CYC),
        .RECOV_CYC (RECOV_CYC),
        .IDLE_CYC  (IDLE_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .op_write  (op_write),
        .cnt_q     (cnt_q),
        .ph_q      (ph_q),
        .ph_d      (ph_d),
        .accept    (accept),
        .capture   (capture),
        .restart   (restart)
    );

    sram_pin_driver #(.CW(CW), .TURN_CYC(TURN_CYC)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph_d      (ph_d),
        .cnt_d     (cnt_d),
        .mem_cs_n  (mem_cs_n),
        .mem_cs    (mem_cs),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_dq_oe (mem_dq_oe)
    );

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
// Protocol checker for the SRAM strobe controller, bound to the top.
// Watches only ports; keeps its own small counters for pulse widths.
module sram_strobe_ctrl_chk #(
    parameter int ADDR_W    = 17,
    parameter int WE_CYC    = 12,
    parameter int RECOV_CYC = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_cs,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);

    localparam int WW = $clog2(WE_CYC + 2);
    localparam int RW = $clog2(RECOV_CYC + 2);

    logic [WW-1:0] we_lo_q;
    logic [RW-1:0] sel_q;
    logic          sel;

    assign sel = !mem_cs_n && mem_cs;

    // Length of the current write-enable low pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)             we_lo_q <= '0;
        else if (mem_we_n)      we_lo_q <= '0;
        else if (!(&we_lo_q))   we_lo_q <= we_lo_q + 1'b1;
    end

    // Cycles selected so far in this stretch, saturating at RECOV_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n)                          sel_q <= '0;
        else if (!sel)                       sel_q <= '0;
        else if (sel_q != RW'(RECOV_CYC))    sel_q <= sel_q + 1'b1;
    end

    p_strobe_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> sel);

    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_oe_we_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_lo_q == WW'(WE_CYC)));

    p_drive_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && $past(!mem_we_n)));

    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr != $past(mem_addr)) |->
            ($past(mem_we_n) && $past(mem_oe_n) && !$past(mem_dq_oe)));

    p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_recovery_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> (sel_q == RW'(RECOV_CYC)));

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .WE_CYC    (WE_CYC),
    .RECOV_CYC (RECOV_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_cs    (mem_cs),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_strobe_ctrl_tb.sv
// Scoreboard bench: a driver task issues requests and queues expected
// read bytes; a monitor pops them on rd_valid. A cycle model of the
// memory checks strobe widths and serves read data only once output
// enable has been low for RD_CYC cycles.
module sram_strobe_ctrl_tb;

    localparam int AW = 17, DW = 8;
    localparam int SETUP = 1, WE = 4, TURN = 2, RD = 3, GAP = 1, RECOV = 5, IDLE = 16;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rd_valid, mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] rd_data, mem_dq_out;
    logic [DW-1:0] mem_dq_in = 8'hEE;
    logic [AW-1:0] mem_addr;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [DW-1:0] exp_mem   [logic [AW-1:0]];
    logic [DW-1:0] model_mem [logic [AW-1:0]];
    logic [DW-1:0] exp_q[$];

    always #2 clk = ~clk;

    sram_strobe_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SETUP), .WE_CYC(WE),
        .TURN_CYC(TURN), .RD_CYC(RD), .GAP_CYC(GAP), .RECOV_CYC(RECOV), .IDLE_CYC(IDLE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mget(input logic [AW-1:0] a);
        return model_mem.exists(a) ? model_mem[a] : 8'hEE;
    endfunction

    // Memory cycle model, evaluated between clock edges.
    int we_lo = 0, oe_lo = 0, sel_cnt = 0, drv_cnt = 0, addr_cnt = 0;
    bit rec_done = 0, oe_in_wr = 0;
    logic p_we_n = 1, p_oe_n = 1, p_dq_oe = 0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] drv_data = '0;
    always @(negedge clk) begin
        if (!rst_n) begin
            we_lo = 0; oe_lo = 0; sel_cnt = 0; drv_cnt = 0; addr_cnt = 0;
            rec_done = 0; oe_in_wr = 0; p_we_n = 1; p_oe_n = 1; p_dq_oe = 0;
            p_addr = mem_addr; mem_dq_in = 8'hEE;
        end else begin
            automatic bit sel = !mem_cs_n && mem_cs;
            automatic bit strobe = !mem_oe_n || !mem_we_n;
            sel_cnt = sel ? sel_cnt + 1 : 0;
            if (!sel) rec_done = 0;
            if (strobe) check(sel, "R2 strobe without select", 0, 1);
            if (strobe && sel && !rec_done) begin
                rec_done = 1;
                check(sel_cnt > RECOV, "R9 selected cycles before first strobe", sel_cnt, RECOV + 1);
            end
            if (mem_addr != p_addr)
                check(p_we_n && p_oe_n && !p_dq_oe, "R6 address moved while busy", 0, 1);
            // Write ends on the rise of write enable or the loss of select.
            if (!p_we_n && (mem_we_n || !sel)) begin
                check(we_lo == WE, "R4 write pulse width", we_lo, WE);
                check(!oe_in_wr, "R4 output enable low during write", 1, 0);
                check(mem_addr == p_addr && addr_cnt >= SETUP + WE,
                      "R4 address setup cycles", addr_cnt, SETUP + WE);
                check(drv_cnt == WE - TURN, "R5 data driven cycles", drv_cnt, WE - TURN);
                model_mem[p_addr] = drv_data;
            end
            addr_cnt = (mem_addr != p_addr) ? 1 : addr_cnt + 1;
            we_lo = (!mem_we_n && sel) ? we_lo + 1 : 0;
            if (mem_we_n) begin drv_cnt = 0; oe_in_wr = 0; end
            else if (!mem_oe_n) oe_in_wr = 1;
            if (mem_dq_oe) begin
                if (mem_we_n || we_lo <= TURN || !mem_oe_n)
                    check(0, "R5 bus driven during turnaround", we_lo, TURN + 1);
                drv_cnt++;
                drv_data = mem_dq_out;
            end
            if (!p_oe_n && mem_oe_n) check(oe_lo == RD, "R3 output enable width", oe_lo, RD);
            oe_lo = (sel && !mem_oe_n && mem_we_n) ? oe_lo + 1 : 0;
            mem_dq_in = (oe_lo >= RD) ? mget(mem_addr) : 8'hEE;
            p_we_n = mem_we_n; p_oe_n = mem_oe_n; p_dq_oe = mem_dq_oe; p_addr = mem_addr;
        end
    end

    // Scoreboard monitor: each read return pops the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) check(0, "R3 unexpected rd_valid", 1, 0);
            else begin
                automatic logic [DW-1:0] e = exp_q.pop_front();
                check(rd_data == e, "R10 read data", rd_data, e);
            end
        end
    end

    // Driver: issue one request and measure how long ready stays low.
    task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit from_sb);
        int lowcnt, expl;
        @(negedge clk);
        check(req_ready, "R7 ready before request", req_ready, 1);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        if (wr) exp_mem[a] = d;
        else exp_q.push_back(exp_mem.exists(a) ? exp_mem[a] : 8'hEE);
        @(negedge clk);
        req_valid = 0;
        lowcnt = 0;
        while (!req_ready && lowcnt < 1000) begin
            lowcnt++;
            @(negedge clk);
        end
        expl = (wr ? SETUP + WE + GAP : SETUP + RD + GAP) + (from_sb ? RECOV : 0);
        check(lowcnt == expl, from_sb ? "R9 busy cycles from standby" : "R7 busy cycles",
              lowcnt, expl);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1, "R1 req_ready", req_ready, 1);
        check(mem_cs_n == 1 && mem_cs == 0, "R1 selects inactive", {mem_cs_n, mem_cs}, 2);
        check(mem_oe_n && mem_we_n, "R1 strobes high", {mem_oe_n, mem_we_n}, 3);
        check(!mem_dq_oe, "R1 bus released", mem_dq_oe, 0);
        check(!rd_valid && rd_data == 0, "R1 read port idle", rd_data, 0);

        do_op(1, 17'h00000, 8'h5A, 1);
        do_op(1, 17'h1FFFF, 8'hA5, 0);
        do_op(0, 17'h00000, 8'h00, 0);
        do_op(0, 17'h1FFFF, 8'h00, 0);
        for (int i = 0; i < 8; i++)
            do_op(1, AW'((i * 23011 + 7) & 17'h1FFFF), DW'(i * 41 + 3), 0);
        for (int i = 7; i >= 0; i--)
            do_op(0, AW'((i * 23011 + 7) & 17'h1FFFF), 8'h00, 0);
        do_op(1, AW'(3 * 23011 + 7), 8'h00, 0);
        do_op(0, AW'(3 * 23011 + 7), 8'h00, 0);
        do_op(1, AW'(3 * 23011 + 7), 8'hFF, 0);
        do_op(0, AW'(3 * 23011 + 7), 8'h00, 0);

        // R8 idle timeout: still selected after IDLE-1 idle cycles, then standby.
        repeat (IDLE - 1) @(negedge clk);
        check(!mem_cs_n && mem_cs, "R8 selected before timeout", {mem_cs_n, mem_cs}, 1);
        @(negedge clk);
        check(mem_cs_n && !mem_cs, "R8 standby after timeout", {mem_cs_n, mem_cs}, 2);
        check(req_ready, "R8 ready in standby", req_ready, 1);
        do_op(0, 17'h1FFFF, 8'h00, 1);

        for (int i = 0; i < 6; i++) begin
            do_op(1, AW'(i * 5), DW'(8'hC0 + i), 0);
            do_op(0, AW'(i * 5), 8'h00, 0);
        end
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3 all reads returned", exp_q.size(), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule